// File: doc/BRIEF.md
# Bloom Filter Set Membership

This block keeps a compact, approximate record of which row addresses belong to one retention bin. The record is a 16-bit vector. Each address is mapped to three bit positions by three separate hash functions. Inserting an address sets those three bits. Testing an address reports whether all three of its bits are set.

A key that was inserted always tests as present. A key that was never inserted may also test as present when its three bits were set by other keys. Entries cannot be removed one at a time. The only way to empty the filter is a synchronous clear of the whole vector. Because the vector has a fixed size and no counters, inserting more keys cannot overflow it; it only becomes denser.

A refresh scheduler inserts rows while profiling. During normal operation it tests a candidate row once per cycle and receives the answer on the following cycle.

Top module: `bloom_filter`

## Requirements
- R1: After reset, and with the asynchronous active-low reset `rst_ni` released, the filter vector is all zero and `hit_o` is 0, so any address first tested reports 0.
- R2: Hash `k` (k = 0, 1, 2) of a 16-bit address `a` is computed in three steps. First, `a` is rotated left by 5·k bits. Second, the result is XORed with a constant: 16'h79B9 for k=0, 16'hF372 for k=1, 16'h6D2B for k=2. Third, the four 4-bit nibbles of that value are XORed together, giving a bit index from 0 to 15.
- R3: When `ins_valid_i` is high and `clr_i` is low, all three bits selected by `ins_addr_i` are 1 after the clock edge. A later test of that address returns 1, so the filter gives no false negative.
- R4: When `tst_valid_i` is high, `hit_o` after the edge is the AND of the three vector bits selected by `tst_addr_i`. It is 0 whenever any of those bits is 0.
- R5: Without `clr_i`, no vector bit ever goes from 1 to 0.
- R6: `hit_o` is registered. It changes only on an edge where `tst_valid_i` is high, and holds its value otherwise.
- R7: An insert and a test in the same cycle are handled so that the test sees the vector as it was before that insert.
- R8: `clr_i` zeroes the whole vector at the next edge. It takes priority over an insert in the same cycle, and that insert is discarded.
- R9: A test in the same cycle as `clr_i` sees the vector as it was before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the whole vector |
| ins_valid_i | input | 1 | Insert request |
| ins_addr_i | input | 16 | Address to insert |
| tst_valid_i | input | 1 | Membership test request |
| tst_addr_i | input | 16 | Address to test |
| hit_o | output | 1 | Registered test result |

## Verification
The addresses used in the tests are 16'h0000, 16'hFFFF, and sparse and dense patterns such as 16'h8001, 16'h5555 and 16'hABCD. These exercise the rotation and the constant mixing of each hash under very different bit populations. A reference model built from the hash definition predicts every result, including false positives. A mismatch in any single index or constant therefore shows up as a wrong hit.

Three same-cycle collisions are driven:
- insert with test, which separates seeing the vector before the write from seeing it after;
- clear with test, which separates the same two views for a clear;
- clear with insert, which shows which operation wins.

Idle cycles between tests show that `hit_o` holds its value rather than re-evaluating.

// File: rtl/bloom_pkg.sv
package bloom_pkg;
  localparam int unsigned ADDR_W_DEF   = 16;
  localparam int unsigned VEC_W_DEF    = 16;
  localparam int unsigned NUM_HASH_DEF = 3;
  localparam int unsigned ROT_STEP_DEF = 5;

  // per-hash mixing constant, golden-ratio multiples
  function automatic logic [31:0] hash_salt(input int unsigned k);
    return 32'h9E3779B9 * (k + 32'd1);
  endfunction
endpackage

// File: rtl/bloom_hash.sv
module bloom_hash
  import bloom_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned SEL      = 0,
  parameter int unsigned ROT_STEP = ROT_STEP_DEF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned ROT    = (SEL * ROT_STEP) % ADDR_W;
  localparam int unsigned CHUNKS = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = CHUNKS * IDX_W;
  localparam logic [31:0] SALT_FULL = hash_salt(SEL);
  localparam logic [ADDR_W-1:0] SALT = SALT_FULL[ADDR_W-1:0];

  logic [ADDR_W-1:0] rot_addr;
  logic [PAD_W-1:0]  mixed;

  generate
    if (ROT == 0) begin : g_norot
      assign rot_addr = addr_i;
    end else begin : g_rot
      assign rot_addr = {addr_i[ADDR_W-1-ROT:0], addr_i[ADDR_W-1:ADDR_W-ROT]};
    end
  endgenerate

  assign mixed = PAD_W'(rot_addr ^ SALT);

  always_comb begin
    idx_o = '0;
    for (int c = 0; c < CHUNKS; c++) idx_o ^= mixed[c*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/bloom_store.sv
module bloom_store #(
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_en_i,
  input  logic [VEC_W-1:0] set_mask_i,
  output logic [VEC_W-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bits_o <= '0;
    else if (clr_i)    bits_o <= '0;          // clear wins over insert
    else if (set_en_i) bits_o <= bits_o | set_mask_i;
  end

  AST_NO_BIT_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((bits_o & $past(bits_o)) == $past(bits_o))); // R5
  AST_INSERT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && !clr_i) |=> ((bits_o & $past(set_mask_i)) == $past(set_mask_i))); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bits_o == '0)); // R8
endmodule

// File: rtl/bloom_probe.sv
module bloom_probe #(
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] bits_i,
  input  logic [VEC_W-1:0] mask_i,
  output logic             hit_o
);
  logic hit_d;
  // every selected bit must be set
  assign hit_d = &(bits_i | ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hit_o <= 1'b0;
    else if (valid_i) hit_o <= hit_d;
  end

  AST_HIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hit_o)); // R6
  AST_EMPTY_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bits_i == '0) |=> !hit_o); // R4
endmodule

// File: rtl/bloom_filter.sv
module bloom_filter
  import bloom_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned VEC_W    = VEC_W_DEF,
  parameter int unsigned NUM_HASH = NUM_HASH_DEF,
  parameter int unsigned ROT_STEP = ROT_STEP_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic              tst_valid_i,
  input  logic [ADDR_W-1:0] tst_addr_i,
  output logic              hit_o
);
  localparam int unsigned IDX_W = $clog2(VEC_W);

  logic [NUM_HASH-1:0][IDX_W-1:0] ins_idx, tst_idx;
  logic [VEC_W-1:0] ins_mask, tst_mask, bits;

  for (genvar k = 0; k < NUM_HASH; k++) begin : g_hash
    bloom_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL(k), .ROT_STEP(ROT_STEP)) u_ins_hash (
      .addr_i(ins_addr_i), .idx_o(ins_idx[k]));
    bloom_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL(k), .ROT_STEP(ROT_STEP)) u_tst_hash (
      .addr_i(tst_addr_i), .idx_o(tst_idx[k]));
  end

  always_comb begin
    ins_mask = '0;
    tst_mask = '0;
    for (int k = 0; k < NUM_HASH; k++) begin
      ins_mask[ins_idx[k]] = 1'b1;
      tst_mask[tst_idx[k]] = 1'b1;
    end
  end

  bloom_store #(.VEC_W(VEC_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .set_en_i(ins_valid_i), .set_mask_i(ins_mask), .bits_o(bits));

  // probe reads the pre-update vector: same-cycle insert/clear not visible
  bloom_probe #(.VEC_W(VEC_W)) u_probe (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(tst_valid_i),
    .bits_i(bits), .mask_i(tst_mask), .hit_o(hit_o));

  AST_MASK_WEIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(ins_mask) >= 1) && ($countones(ins_mask) <= NUM_HASH)); // R2
  AST_SELF_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !clr_i && tst_valid_i && ins_addr_i == tst_addr_i) ##1
    (tst_valid_i && $past(tst_addr_i) == tst_addr_i && !clr_i) |=> hit_o); // R3
endmodule

// File: tb/tb_bloom_filter.sv
module tb_bloom_filter;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0;
  logic ins_valid_i = 1'b0;
  logic [15:0] ins_addr_i = '0;
  logic tst_valid_i = 1'b0;
  logic [15:0] tst_addr_i = '0;
  logic hit_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model = '0;
  logic model_hit = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bloom_filter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .ins_valid_i(ins_valid_i), .ins_addr_i(ins_addr_i),
    .tst_valid_i(tst_valid_i), .tst_addr_i(tst_addr_i), .hit_o(hit_o));

  // R2: index from rotate, salt, nibble fold
  function automatic logic [3:0] ref_idx(input logic [15:0] a, input int k);
    logic [15:0] salts [3] = '{16'h79B9, 16'hF372, 16'h6D2B};
    logic [15:0] r;
    r = a;
    for (int i = 0; i < 5*k; i++) r = {r[14:0], r[15]};
    r = r ^ salts[k];
    return r[3:0] ^ r[7:4] ^ r[11:8] ^ r[15:12];
  endfunction

  function automatic logic [15:0] ref_mask(input logic [15:0] a);
    logic [15:0] m = '0;
    for (int k = 0; k < 3; k++) m[ref_idx(a, k)] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit_o=%0b expected %0b", req, act, exp);
    end
  endtask

  // drive at negedge, update model at posedge, sample at next negedge
  task automatic step(input logic iv, input logic [15:0] ia, input logic tv,
                      input logic [15:0] ta, input logic cl, input string req);
    ins_valid_i = iv; ins_addr_i = ia;
    tst_valid_i = tv; tst_addr_i = ta; clr_i = cl;
    @(posedge clk_i);
    if (tv) model_hit = ((model & ref_mask(ta)) == ref_mask(ta));
    if (cl) model = '0;
    else if (iv) model = model | ref_mask(ia);
    @(negedge clk_i);
    ins_valid_i = 1'b0; tst_valid_i = 1'b0; clr_i = 1'b0;
    check(req, hit_o, model_hit);
  endtask

  // {ins_v, ins_a, tst_v, tst_a, clr}
  localparam int NV = 17;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 16'h0000, 1'b1, 16'h1234, 1'b0},
    {1'b1, 16'h1234, 1'b0, 16'h0000, 1'b0},
    {1'b0, 16'h0000, 1'b1, 16'h1234, 1'b0},
    {1'b1, 16'hABCD, 1'b1, 16'hABCD, 1'b0},
    {1'b0, 16'h0000, 1'b1, 16'hABCD, 1'b0},
    {1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0},
    {1'b0, 16'h0000, 1'b1, 16'hFFFF, 1'b0},
    {1'b1, 16'h8001, 1'b1, 16'h1234, 1'b0},
    {1'b0, 16'h0000, 1'b1, 16'h5555, 1'b0},
    {1'b1, 16'hFFFF, 1'b0, 16'h0000, 1'b0},
    {1'b0, 16'h0000, 1'b1, 16'hFFFF, 1'b0},
    {1'b1, 16'h4242, 1'b1, 16'h1234, 1'b1},
    {1'b0, 16'h0000, 1'b1, 16'h4242, 1'b0},
    {1'b1, 16'h4242, 1'b0, 16'h0000, 1'b0},
    {1'b0, 16'h0000, 1'b1, 16'h4242, 1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [34:0] v;
    string req;
    repeat (3) @(negedge clk_i);
    check("R1 reset value", hit_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1'b0, 16'h0, 1'b1, 16'hFFFF, 1'b0, "R1 empty filter miss");

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (!v[17])                req = "R6 hold without test";
      else if (v[0])             req = "R9 test with clear";
      else if (v[34] && v[17])   req = "R7 test with insert";
      else                       req = "R2 R4 lookup";
      step(v[34], v[33:18], v[17], v[16:1], v[0], req);
    end

    // R3 directed: every inserted key hits
    step(1'b1, 16'h0F0F, 1'b0, 16'h0, 1'b0, "R6 hold during insert");
    step(1'b1, 16'h7E81, 1'b0, 16'h0, 1'b0, "R6 hold during insert");
    step(1'b0, 16'h0, 1'b1, 16'h0F0F, 1'b0, "R3 no false negative");
    check("R3 inserted key present", hit_o, 1'b1);
    step(1'b0, 16'h0, 1'b1, 16'h7E81, 1'b0, "R3 no false negative");
    check("R3 inserted key present", hit_o, 1'b1);
    // R5: bits survive many other inserts
    for (int i = 0; i < 8; i++)
      step(1'b1, 16'(i * 16'h1111), 1'b0, 16'h0, 1'b0, "R5 insert burst");
    step(1'b0, 16'h0, 1'b1, 16'h0F0F, 1'b0, "R5 bits kept");
    check("R5 earlier key still present", hit_o, 1'b1);
    // R8: clear alone, then keys gone
    step(1'b0, 16'h0, 1'b0, 16'h0, 1'b1, "R8 clear");
    step(1'b0, 16'h0, 1'b1, 16'h0F0F, 1'b0, "R8 cleared");
    check("R8 key gone after clear", hit_o, 1'b0);
    step(1'b0, 16'h0, 1'b1, 16'h7E81, 1'b0, "R8 cleared");
    check("R8 key gone after clear", hit_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule